// File: doc/BRIEF.md
# Serial Bus Word Adapter

This block connects a bus controller to one bit-serial command/data line. Every word on the line is 28 bits long and moves one bit per strobe of a bit-enable input, most significant bit first. A start-of-word marker travels beside the data bit so that the receiving end can find word boundaries. For transmission the controller supplies a word type (command or data), a 5-bit unit address and a 19-bit body. The adapter adds the synchronization field that marks the type and a parity bit, then shifts the word out.

For reception the adapter gathers 28 bits that start at a start-of-word marker and checks the synchronization field and the parity. It then presents type, address, body and a two-bit error code with a one-cycle valid pulse.

An ownership input says whether this node commands the bus. The transmitter accepts a word and drives the line only while this node owns the bus. Otherwise the adapter stays a listener. In a data word the body is split into 16 data bits above 3 validity bits. The adapter does not look into the body.

Top module: `sbw_adapter`

## Requirements
- R1: A word is laid out MSB first as sync[27:25], address[24:20], body[19:1], parity[0]. The transmitter presents bit 27 first, with `line_sof_out` high, and advances one bit on each clock edge where `bit_en` is high.
- R2: The transmitter sets the sync field to 3'b101 when `tx_is_cmd` is 1 and to 3'b010 when it is 0.
- R3: The transmitter sets the parity bit so that the 28-bit word holds an odd number of ones.
- R4: `tx_ready` is high only when no word is being sent and `own_bus` is 1. A `tx_req` while `tx_ready` is low is ignored and sends no word, even after ownership returns.
- R5: `line_oe` is high only while a word is being shifted out and `own_bus` is 1.
- R6: A word is received from a `bit_en` strobe with `line_sof_in` high plus 27 further strobes. `rx_valid` is high for exactly the one clock after the final strobe, with `rx_addr` = bits[24:20] and `rx_body` = bits[19:1]. For a data word these are data in body[18:3] and validity in body[2:0].
- R7: A received sync field of 3'b101 sets `rx_is_cmd` to 1. A received 3'b010 sets it to 0. Any other pattern sets `rx_err[0]` and clears `rx_is_cmd`.
- R8: A received word with an even number of ones sets `rx_err[1]`. Both error bits can be set together.
- R9: A `line_sof_in` strobe in the middle of a word discards the partial word and starts a new one. The abandoned word produces no result.
- R10: After reset, `line_oe` and `rx_valid` are 0 and `tx_ready` follows `own_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit strobe: one line bit per high cycle |
| own_bus | input | 1 | This node commands the bus |
| tx_req | input | 1 | Request to send a word |
| tx_is_cmd | input | 1 | 1 = command word, 0 = data word |
| tx_addr | input | 5 | Destination/source address |
| tx_body | input | 19 | Command code or data+validity |
| tx_ready | output | 1 | Transmitter can accept a request |
| line_out | output | 1 | Serial data bit driven to the line |
| line_sof_out | output | 1 | Start-of-word marker for line_out |
| line_oe | output | 1 | Line driver enable |
| line_in | input | 1 | Serial data bit from the line |
| line_sof_in | input | 1 | Start-of-word marker for line_in |
| rx_valid | output | 1 | One-cycle pulse: received word ready |
| rx_is_cmd | output | 1 | Received word is a command |
| rx_addr | output | 5 | Received address |
| rx_body | output | 19 | Received body |
| rx_err | output | 2 | bit0 sync error, bit1 parity error |

## Verification
A request accepted at one edge shows `tx_ready` low and `line_sof_out` high in the very next cycle. Each line bit is then due for the strobe that consumes it, so the bench captures `line_out` only in cycles where `bit_en` is high and `line_oe` is set. A received result is due exactly one clock after the strobe that carries bit 0. The bench therefore checks `rx_valid` at the first falling edge after that strobe, while a monitor compares the result fields against a queue of words computed from the requirements. Ownership and ignored-request cases are checked over a window of more than one word time, during which `line_oe` must never rise.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
   typedef enum logic [0:0] {
      TX_IDLE  = 1'b0,
      TX_SHIFT = 1'b1
   } tx_state_e;

   localparam int ERR_SYNC_BIT = 0;
   localparam int ERR_PAR_BIT  = 1;
   localparam int ERR_W        = 2;
endpackage

// File: rtl/sbw_tx.sv
module sbw_tx
   import sbw_pkg::*;
#(
   parameter int SYNC_W = 3,
   parameter int ADDR_W = 5,
   parameter int BODY_W = 19,
   parameter logic [SYNC_W-1:0] SYNC_CMD = 3'b101,
   parameter logic [SYNC_W-1:0] SYNC_DAT = 3'b010,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              own_bus,
   input  logic              req,
   input  logic              is_cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BODY_W-1:0] body,
   output logic              ready,
   output logic              ser_out,
   output logic              sof_out,
   output logic              oe
);
   localparam int WORD_W = SYNC_W + ADDR_W + BODY_W + 1;
   localparam int CNT_W  = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   tx_state_e           state;
   logic [WORD_W-1:0]   shreg;
   logic [CNT_W-1:0]    cnt;
   logic [WORD_W-2:0]   head;
   logic                par;

   assign head = {(is_cmd ? SYNC_CMD : SYNC_DAT), addr, body};

   generate
      if (ODD_PARITY) begin : g_odd
         assign par = ~(^head);
      end else begin : g_even
         assign par = ^head;
      end
   endgenerate

   assign ready   = (state == TX_IDLE) && own_bus;
   assign ser_out = shreg[WORD_W-1];
   assign sof_out = (state == TX_SHIFT) && (cnt == '0);
   assign oe      = (state == TX_SHIFT) && own_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         shreg <= '0;
         cnt   <= '0;
      end else begin
         case (state)
            TX_IDLE: begin
               if (req && ready) begin
                  shreg <= {head, par};
                  cnt   <= '0;
                  state <= TX_SHIFT;
               end
            end
            default: begin
               if (bit_en) begin
                  shreg <= {shreg[WORD_W-2:0], 1'b0};
                  if (cnt == LAST) begin
                     state <= TX_IDLE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sbw_rx.sv
module sbw_rx #(
   parameter int WORD_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              ser_in,
   input  logic              sof_in,
   output logic              done,
   output logic [WORD_W-1:0] word
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-2:0] sreg;
   logic [CNT_W-1:0]  cnt;
   logic              active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '0;
         cnt    <= '0;
         active <= 1'b0;
         done   <= 1'b0;
         word   <= '0;
      end else begin
         done <= 1'b0;
         if (bit_en) begin
            if (sof_in) begin
               sreg   <= {sreg[WORD_W-3:0], ser_in};
               cnt    <= CNT_W'(1);
               active <= 1'b1;
            end else if (active) begin
               if (cnt == LAST) begin
                  word   <= {sreg, ser_in};
                  done   <= 1'b1;
                  active <= 1'b0;
                  cnt    <= '0;
               end else begin
                  sreg <= {sreg[WORD_W-3:0], ser_in};
                  cnt  <= cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sbw_word_chk.sv
module sbw_word_chk
   import sbw_pkg::*;
#(
   parameter int SYNC_W = 3,
   parameter int ADDR_W = 5,
   parameter int BODY_W = 19,
   parameter logic [SYNC_W-1:0] SYNC_CMD = 3'b101,
   parameter logic [SYNC_W-1:0] SYNC_DAT = 3'b010,
   parameter bit ODD_PARITY = 1'b1,
   localparam int WORD_W = SYNC_W + ADDR_W + BODY_W + 1
) (
   input  logic [WORD_W-1:0] word,
   output logic              is_cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BODY_W-1:0] body,
   output logic [ERR_W-1:0]  err
);
   logic [SYNC_W-1:0] sync;
   logic              par_bad;

   assign sync = word[WORD_W-1 -: SYNC_W];
   assign addr = word[BODY_W+ADDR_W : BODY_W+1];
   assign body = word[BODY_W:1];

   generate
      if (ODD_PARITY) begin : g_odd
         assign par_bad = ~(^word);
      end else begin : g_even
         assign par_bad = ^word;
      end
   endgenerate

   always_comb begin
      is_cmd            = (sync == SYNC_CMD);
      err               = '0;
      err[ERR_SYNC_BIT] = (sync != SYNC_CMD) && (sync != SYNC_DAT);
      err[ERR_PAR_BIT]  = par_bad;
   end
endmodule

// File: rtl/sbw_adapter.sv
module sbw_adapter
   import sbw_pkg::*;
#(
   parameter int SYNC_W = 3,
   parameter int ADDR_W = 5,
   parameter int BODY_W = 19,
   parameter logic [SYNC_W-1:0] SYNC_CMD = 3'b101,
   parameter logic [SYNC_W-1:0] SYNC_DAT = 3'b010,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              own_bus,
   input  logic              tx_req,
   input  logic              tx_is_cmd,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic [BODY_W-1:0] tx_body,
   output logic              tx_ready,
   output logic              line_out,
   output logic              line_sof_out,
   output logic              line_oe,
   input  logic              line_in,
   input  logic              line_sof_in,
   output logic              rx_valid,
   output logic              rx_is_cmd,
   output logic [ADDR_W-1:0] rx_addr,
   output logic [BODY_W-1:0] rx_body,
   output logic [ERR_W-1:0]  rx_err
);
   localparam int WORD_W = SYNC_W + ADDR_W + BODY_W + 1;

   generate
      if (SYNC_W < 2) begin : g_bad_sync_w
         $error("sbw_adapter: SYNC_W must be at least 2");
      end
      if (SYNC_CMD == SYNC_DAT) begin : g_bad_sync_pat
         $error("sbw_adapter: command and data sync patterns must differ");
      end
      if (ADDR_W < 1 || BODY_W < 1) begin : g_bad_fields
         $error("sbw_adapter: address and body need at least one bit");
      end
   endgenerate

   logic [WORD_W-1:0] rx_word;

   sbw_tx #(
      .SYNC_W(SYNC_W), .ADDR_W(ADDR_W), .BODY_W(BODY_W),
      .SYNC_CMD(SYNC_CMD), .SYNC_DAT(SYNC_DAT), .ODD_PARITY(ODD_PARITY)
   ) tx_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .own_bus(own_bus),
      .req(tx_req), .is_cmd(tx_is_cmd), .addr(tx_addr), .body(tx_body),
      .ready(tx_ready), .ser_out(line_out), .sof_out(line_sof_out), .oe(line_oe)
   );

   sbw_rx #(.WORD_W(WORD_W)) rx_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(line_in),
      .sof_in(line_sof_in), .done(rx_valid), .word(rx_word)
   );

   sbw_word_chk #(
      .SYNC_W(SYNC_W), .ADDR_W(ADDR_W), .BODY_W(BODY_W),
      .SYNC_CMD(SYNC_CMD), .SYNC_DAT(SYNC_DAT), .ODD_PARITY(ODD_PARITY)
   ) chk_i (
      .word(rx_word), .is_cmd(rx_is_cmd), .addr(rx_addr),
      .body(rx_body), .err(rx_err)
   );
endmodule

// File: rtl/sbw_adapter_chk.sv
module sbw_adapter_chk (
   input logic clk,
   input logic rst_n,
   input logic own_bus,
   input logic tx_req,
   input logic tx_ready,
   input logic line_sof_out,
   input logic line_oe,
   input logic rx_valid
);
   // R4: no acceptance without bus ownership
   assert_ready_needs_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !own_bus |-> !tx_ready);

   // R4, R1: an accepted request starts a word and blocks further requests
   assert_accept_starts_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && tx_ready) |=> (line_sof_out && !tx_ready));

   // R4: busy while the first bit is on the line
   assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      line_sof_out |-> !tx_ready);

   // R5: line driver only with ownership
   assert_oe_needs_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> own_bus);

   // R6: result is a single-cycle pulse
   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
endmodule

bind sbw_adapter sbw_adapter_chk sbw_adapter_chk_i (
   .clk(clk), .rst_n(rst_n), .own_bus(own_bus), .tx_req(tx_req),
   .tx_ready(tx_ready), .line_sof_out(line_sof_out), .line_oe(line_oe),
   .rx_valid(rx_valid)
);

// File: tb/sbw_adapter_tb_top.sv
module sbw_adapter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        own_bus = 1'b1;
   logic        tx_req = 1'b0;
   logic        tx_is_cmd = 1'b0;
   logic [4:0]  tx_addr = '0;
   logic [18:0] tx_body = '0;
   logic        tx_ready, line_out, line_sof_out, line_oe;
   logic        line_in = 1'b0;
   logic        line_sof_in = 1'b0;
   logic        rx_valid, rx_is_cmd;
   logic [4:0]  rx_addr;
   logic [18:0] rx_body;
   logic [1:0]  rx_err;

   int checks = 0;
   int failures = 0;

   typedef struct packed {
      logic [1:0]  err;
      logic        is_cmd;
      logic [4:0]  addr;
      logic [18:0] body;
   } rx_item_t;

   rx_item_t    rxq[$];
   logic [27:0] txq[$];

   always #2.5 clk = ~clk;

   sbw_adapter dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .own_bus(own_bus),
      .tx_req(tx_req), .tx_is_cmd(tx_is_cmd), .tx_addr(tx_addr), .tx_body(tx_body),
      .tx_ready(tx_ready), .line_out(line_out), .line_sof_out(line_sof_out),
      .line_oe(line_oe), .line_in(line_in), .line_sof_in(line_sof_in),
      .rx_valid(rx_valid), .rx_is_cmd(rx_is_cmd), .rx_addr(rx_addr),
      .rx_body(rx_body), .rx_err(rx_err)
   );

   // bit strobe: one high cycle in four, changed just after the rising edge
   int div = 0;
   always @(posedge clk) begin
      #1;
      div = (div + 1) % 4;
      bit_en = (div == 0);
   end

   task automatic check(input bit ok, input string req, input logic [63:0] got,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   function automatic logic [27:0] build(input logic [2:0] s, input logic [4:0] a,
                                         input logic [18:0] b, input bit flip_par);
      logic [26:0] h;
      logic        p;
      h = {s, a, b};
      p = ($countones(h) % 2 == 0);
      return {h, p ^ flip_par};
   endfunction

   // ---------------- transmit side ----------------
   task automatic tx_send(input bit cmd, input logic [4:0] a, input logic [18:0] b);
      txq.push_back(build(cmd ? 3'b101 : 3'b010, a, b, 1'b0));
      while (!tx_ready) @(negedge clk);
      tx_req = 1'b1; tx_is_cmd = cmd; tx_addr = a; tx_body = b;
      @(negedge clk);
      tx_req = 1'b0;
      check(tx_ready == 1'b0, "R4 busy after accept", 64'(tx_ready), 64'd0);
      check(line_sof_out == 1'b1, "R1 sof on first bit", 64'(line_sof_out), 64'd1);
   endtask

   logic [27:0] cap = '0;
   int          nb = 0;
   always @(negedge clk) begin
      if (rst_n && bit_en && line_oe) begin
         if (line_sof_out) nb = 0;
         cap = {cap[26:0], line_out};
         nb++;
         if (nb == 28) begin
            nb = 0;
            if (txq.size() == 0) begin
               check(1'b0, "R4 unexpected word", 64'(cap), 64'd0);
            end else begin
               logic [27:0] e;
               e = txq.pop_front();
               // R1 R2 R3: layout, sync pattern, odd parity
               check(cap == e, "R1/R2/R3 tx word", 64'(cap), 64'(e));
            end
         end
      end
   end

   // ---------------- receive side ----------------
   task automatic put_bit(input logic b, input logic sof);
      line_in = b; line_sof_in = sof;
      @(posedge clk);
      while (!bit_en) @(posedge clk);
      @(negedge clk);
      line_sof_in = 1'b0;
   endtask

   task automatic rx_send(input logic [27:0] w, input int nbits, input bit expect_it);
      if (expect_it) begin
         rx_item_t it;
         it.err    = {($countones(w) % 2 == 0),
                      (w[27:25] != 3'b101 && w[27:25] != 3'b010)};
         it.is_cmd = (w[27:25] == 3'b101);
         it.addr   = w[24:20];
         it.body   = w[19:1];
         rxq.push_back(it);
      end
      for (int i = 27; i > 27 - nbits; i--) put_bit(w[i], i == 27);
      if (expect_it)
         check(rx_valid == 1'b1, "R6 valid one clock after last strobe", 64'(rx_valid), 64'd1);
   endtask

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (rxq.size() == 0) begin
            check(1'b0, "R9 unexpected rx result", 64'({rx_err, rx_addr}), 64'd0);
         end else begin
            rx_item_t e, g;
            e = rxq.pop_front();
            g = {rx_err, rx_is_cmd, rx_addr, rx_body};
            // R6 R7 R8 fields and error code
            check(g == e, "R6/R7/R8 rx result", 64'(g), 64'(e));
         end
      end
   end

   // ---------------- sequence ----------------
   task automatic run_tests();
      int oe_seen;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(line_oe == 1'b0, "R10 oe after reset", 64'(line_oe), 64'd0);
      check(rx_valid == 1'b0, "R10 valid after reset", 64'(rx_valid), 64'd0);
      check(tx_ready == 1'b1, "R10 ready follows owner", 64'(tx_ready), 64'd1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2 R3: command and data words, several bit patterns
      tx_send(1'b1, 5'h15, 19'h5A5A5);
      wait (txq.size() == 0); @(negedge clk);
      tx_send(1'b0, 5'h00, {16'hBEEF, 3'b101});
      wait (txq.size() == 0); @(negedge clk);
      tx_send(1'b0, 5'h1F, 19'h7FFFF);
      wait (txq.size() == 0); @(negedge clk);
      tx_send(1'b1, 5'h01, 19'h00000);
      wait (txq.size() == 0); @(negedge clk);

      // R4 R5: no ownership, request ignored
      own_bus = 1'b0;
      @(negedge clk);
      check(tx_ready == 1'b0, "R4 ready without owner", 64'(tx_ready), 64'd0);
      tx_req = 1'b1; tx_is_cmd = 1'b1; tx_addr = 5'h0A; tx_body = 19'h12345;
      @(negedge clk);
      tx_req = 1'b0;
      oe_seen = 0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (line_oe || line_sof_out) oe_seen++;
      end
      check(oe_seen == 0, "R5 no drive without owner", 64'(oe_seen), 64'd0);
      own_bus = 1'b1;
      @(negedge clk);
      check(tx_ready == 1'b1, "R4 ready after owner returns", 64'(tx_ready), 64'd1);
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (line_oe) oe_seen++;
      end
      check(oe_seen == 0, "R4 refused request not replayed", 64'(oe_seen), 64'd0);

      // R6 R7 R8: receive good and bad words
      rx_send(build(3'b101, 5'h13, 19'h2AAAA, 1'b0), 28, 1'b1);
      rx_send(build(3'b010, 5'h04, {16'hC0DE, 3'b011}, 1'b0), 28, 1'b1);
      rx_send(build(3'b111, 5'h07, 19'h00F0F, 1'b0), 28, 1'b1);
      rx_send(build(3'b000, 5'h1E, 19'h40001, 1'b0), 28, 1'b1);
      rx_send(build(3'b101, 5'h02, 19'h11111, 1'b1), 28, 1'b1);
      rx_send(build(3'b110, 5'h11, 19'h7E7E7, 1'b1), 28, 1'b1);

      // R9: partial word then a fresh start marker
      rx_send(build(3'b010, 5'h0F, 19'h33333, 1'b0), 10, 1'b0);
      rx_send(build(3'b010, 5'h18, 19'h0ABCD, 1'b0), 28, 1'b1);
      repeat (20) @(negedge clk);

      check(rxq.size() == 0, "R6 all rx results seen", 64'(rxq.size()), 64'd0);
      check(txq.size() == 0, "R1 all tx words seen", 64'(txq.size()), 64'd0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "watchdog expired", 64'd1, 64'd0);
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule